// File: doc/BRIEF.md
# Bounded Write Guard with Shared Top Region

This block sits between instruction decode and a 16-bit word-addressed memory, and checks every write before the memory sees it. Three boundary registers are loaded from a shared data bus, each by its own strobe from decode. A low bound and a high bound define the window that the running task may write. A third bound marks the bottom of a shared region that runs up to the top of the address space.

A write whose address is inside the window always passes. A write into the shared region passes only while the shared-write enable is high. Any other write is blocked. A blocked write has its memory write strobe removed in the same cycle. It also sets a sticky interrupt request that keeps the offending address until software clears it. While protection is disabled, every write passes unchanged. Read cycles never reach the checker.

Top module: `wguard`

## Requirements
- R1: Each of the three bounds (low, high, shared base) loads from `bound_data` at the clock edge where its own strobe is high. The new value governs writes from the next cycle on. A write in the load cycle is still judged against the old value.
- R2: A blocked write drives `mem_we_o` low in the same cycle as the request. A passed write drives `mem_we_o` high in that cycle.
- R3: With protection on, a write with low <= address <= high passes. Both ends are included. Addresses one below low and one above high are blocked when they are outside the shared region.
- R4: A write to an address >= shared base and outside the window passes only while `shared_we` is high. While `shared_we` is low it is blocked. This includes the shared base itself and 0xFFFF.
- R5: The cycle after the first blocked write, `viol_irq` is high and `viol_addr` holds that write's address. Both stay unchanged through later blocked writes until `viol_clr`. A clear with no new violation drops `viol_irq` at the next edge. A blocked write in the same cycle as a clear sets the flag again and captures the new address.
- R6: While `prot_en` is low, `mem_we_o` follows `mem_wr_i` for any address and no violation is raised.
- R7: With `mem_wr_i` low, `mem_we_o` stays low and no violation is raised, whatever the address.
- R8: After reset, low is 0x0000, high is 0xFFFF and shared base is 0xFFFF. `viol_irq` is 0, `viol_addr` is 0x0000, and every write passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prot_en | input | 1 | Protection active |
| shared_we | input | 1 | Permit writes into the shared top region |
| ld_low | input | 1 | Load low bound from bound_data |
| ld_high | input | 1 | Load high bound from bound_data |
| ld_shared | input | 1 | Load shared base from bound_data |
| bound_data | input | 16 | Value for bound loads |
| mem_wr_i | input | 1 | Write request from the processor |
| mem_addr | input | 16 | Word address of the request |
| mem_we_o | output | 1 | Qualified write strobe to memory |
| viol_irq | output | 1 | Sticky protection-violation interrupt request |
| viol_addr | output | 16 | Address of the first unserviced violation |
| viol_clr | input | 1 | Clear the violation flag |

## Verification
A wrong bound register shows at once on `mem_we_o`, in the same cycle as the first write that lands on either side of that bound. For that reason the vectors sit on each edge and one word beyond it. A corrupted violation flag or captured address shows one edge after the blocked write, when `viol_irq` and `viol_addr` are sampled. A lost sticky hold shows only after a second violation, so the bench forces a second violation before it clears the flag.

// File: rtl/wguard.sv
module wguard #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prot_en,
  input  logic          shared_we,
  input  logic          ld_low,
  input  logic          ld_high,
  input  logic          ld_shared,
  input  logic [AW-1:0] bound_data,
  input  logic          mem_wr_i,
  input  logic [AW-1:0] mem_addr,
  output logic          mem_we_o,
  output logic          viol_irq,
  output logic [AW-1:0] viol_addr,
  input  logic          viol_clr
);
  localparam logic [AW-1:0] TOP = {AW{1'b1}};

  logic [AW-1:0] b_low, b_high, b_shared;
  logic in_win, in_shared, permit, blocked;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      b_low    <= '0;
      b_high   <= TOP;
      b_shared <= TOP;
    end else begin
      if (ld_low)    b_low    <= bound_data;
      if (ld_high)   b_high   <= bound_data;
      if (ld_shared) b_shared <= bound_data;
    end

  assign in_win    = (mem_addr >= b_low) && (mem_addr <= b_high);
  assign in_shared = mem_addr >= b_shared;
  assign permit    = !prot_en || in_win || (in_shared && shared_we);
  assign blocked   = mem_wr_i && !permit;
  assign mem_we_o  = mem_wr_i && permit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      viol_irq  <= 1'b0;
      viol_addr <= '0;
    end else if (blocked) begin
      viol_irq <= 1'b1;
      if (!viol_irq || viol_clr) viol_addr <= mem_addr;
    end else if (viol_clr) begin
      viol_irq <= 1'b0;
    end

  a_r2_block_raises: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_i && !mem_we_o |=> viol_irq);
  a_r6_off_passes: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_en |-> mem_we_o == mem_wr_i);
  a_r7_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_i |-> !mem_we_o);
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    viol_irq && !viol_clr |=> viol_irq && $stable(viol_addr));
  a_r3_window: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_i && mem_addr >= b_low && mem_addr <= b_high |-> mem_we_o);
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    viol_clr && !(mem_wr_i && !mem_we_o) |=> !viol_irq);
endmodule

// File: tb/tb_wguard.sv
module tb_wguard;
  logic clk = 0, rst_n = 0;
  logic prot_en = 0, shared_we = 0, ld_low = 0, ld_high = 0, ld_shared = 0;
  logic [15:0] bound_data = 0, mem_addr = 0;
  logic mem_wr_i = 0, viol_clr = 0;
  logic mem_we_o, viol_irq;
  logic [15:0] viol_addr;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  wguard dut (.clk, .rst_n, .prot_en, .shared_we, .ld_low, .ld_high, .ld_shared,
              .bound_data, .mem_wr_i, .mem_addr, .mem_we_o, .viol_irq, .viol_addr, .viol_clr);

  // {prot_en, shared_we, expected strobe, address}; window 0x1000..0x1FFF, shared base 0xF000
  localparam logic [18:0] VEC [0:11] = '{
    {3'b101, 16'h1000}, {3'b101, 16'h1FFF}, {3'b100, 16'h0FFF}, {3'b100, 16'h2000},
    {3'b100, 16'hF000}, {3'b100, 16'hFFFF}, {3'b111, 16'hF000}, {3'b111, 16'hFFFF},
    {3'b110, 16'hEFFF}, {3'b111, 16'h1800}, {3'b001, 16'h0000}, {3'b011, 16'h8000}};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input int which, input logic [15:0] v);
    @(negedge clk);
    bound_data = v;
    ld_low = (which == 0); ld_high = (which == 1); ld_shared = (which == 2);
    @(negedge clk);
    ld_low = 0; ld_high = 0; ld_shared = 0;
  endtask

  task automatic clear_flag();
    @(negedge clk); viol_clr = 1;
    @(negedge clk); viol_clr = 0;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(viol_irq == 0, "R8 irq after reset", viol_irq, 0);
    chk(viol_addr == 0, "R8 addr after reset", viol_addr, 0);
    prot_en = 1; mem_wr_i = 1; mem_addr = 16'h7777; #1;
    chk(mem_we_o == 1, "R8 reset bounds pass write", mem_we_o, 1);
    mem_addr = 16'hFFFF; #1;
    chk(mem_we_o == 1, "R8 reset top pass", mem_we_o, 1);
    @(negedge clk); mem_wr_i = 0; #1;
    chk(viol_irq == 0, "R8 no violation", viol_irq, 0);

    load(0, 16'h1000); load(1, 16'h1FFF); load(2, 16'hF000);

    foreach (VEC[i]) begin
      @(negedge clk);
      prot_en = VEC[i][18]; shared_we = VEC[i][17]; mem_addr = VEC[i][15:0]; mem_wr_i = 1; #1;
      chk(mem_we_o == VEC[i][16], $sformatf("R2/R3/R4/R6 strobe vec%0d", i), mem_we_o, VEC[i][16]);
      @(negedge clk); mem_wr_i = 0; #1;
      chk(viol_irq == !VEC[i][16], $sformatf("R5/R6 irq vec%0d", i), viol_irq, !VEC[i][16]);
      if (!VEC[i][16])
        chk(viol_addr == VEC[i][15:0], $sformatf("R5 addr vec%0d", i), viol_addr, VEC[i][15:0]);
      clear_flag(); #1;
      chk(viol_irq == 0, $sformatf("R5 clear vec%0d", i), viol_irq, 0);
    end

    // R7: no write request at a forbidden address
    @(negedge clk); prot_en = 1; shared_we = 0; mem_addr = 16'h0005; mem_wr_i = 0; #1;
    chk(mem_we_o == 0, "R7 no strobe", mem_we_o, 0);
    @(negedge clk); #1;
    chk(viol_irq == 0, "R7 no violation", viol_irq, 0);

    // R5 sticky: second violation does not replace address
    @(negedge clk); mem_wr_i = 1; mem_addr = 16'h0100;
    @(negedge clk); mem_addr = 16'h3000;
    @(negedge clk); mem_wr_i = 0; #1;
    chk(viol_irq == 1, "R5 sticky irq", viol_irq, 1);
    chk(viol_addr == 16'h0100, "R5 first address kept", viol_addr, 16'h0100);
    // R5: new violation together with clear wins
    @(negedge clk); mem_wr_i = 1; mem_addr = 16'h4444; viol_clr = 1;
    @(negedge clk); mem_wr_i = 0; viol_clr = 0; #1;
    chk(viol_irq == 1, "R5 set over clear", viol_irq, 1);
    chk(viol_addr == 16'h4444, "R5 new address on clear", viol_addr, 16'h4444);
    clear_flag();

    // R1: write in load cycle uses old low bound
    @(negedge clk); bound_data = 16'h3000; ld_low = 1; mem_wr_i = 1; mem_addr = 16'h1000; #1;
    chk(mem_we_o == 1, "R1 old bound in load cycle", mem_we_o, 1);
    @(negedge clk); ld_low = 0; #1;
    chk(mem_we_o == 0, "R1 new low bound active", mem_we_o, 0);
    @(negedge clk); mem_wr_i = 0; #1;
    chk(viol_addr == 16'h1000, "R1 violation address", viol_addr, 16'h1000);
    clear_flag();
    load(1, 16'h3FFF);
    @(negedge clk); mem_wr_i = 1; mem_addr = 16'h3FFF; #1;
    chk(mem_we_o == 1, "R1 new high bound", mem_we_o, 1);
    load(2, 16'h9000);
    @(negedge clk); shared_we = 1; mem_addr = 16'h9000; #1;
    chk(mem_we_o == 1, "R1 new shared base", mem_we_o, 1);
    mem_addr = 16'h8FFF; #1;
    chk(mem_we_o == 0, "R1 below new shared base", mem_we_o, 0);
    @(negedge clk); mem_wr_i = 0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule